// File: doc/BRIEF.md
# Prescaled Reciprocal Period Counter

This block measures how long an unknown signal takes to complete a programmable number of its own cycles, expressed in cycles of the reference clock. The unknown signal arrives as an edge strobe that is already synchronised to the reference clock: one cycle high for each rising edge. After a start command, the first strobe opens a measurement window. The window closes on the strobe that completes P input periods. Both ends of the window therefore fall on input edges, and the reference clock is only the thing being counted. The reading carries at most one reference cycle of quantisation error, whatever the input frequency.

The block reports the raw span N and the ratio P it applied. Downstream arithmetic then forms the input frequency as P times the reference frequency divided by N. A caller normally picks P so that the window lasts about one second, which makes the relative resolution roughly one reference period divided by one second. A finished measurement raises a one-cycle done strobe. Along with it come a flag for a span too long for the counter and a flag for an abort when no prescaled edge came in time.

Top module: `recip_period_counter`

## Requirements
- R1: After reset, done_o, ovf_o and tmo_o are 0, and count_o and psc_o are 0.
- R2: A start_i high in a cycle where no measurement is in progress begins one, latching psc_ratio_i and timeout_i. An edge_i strobe in that same cycle is ignored. The window opens on the first edge_i strobe in a later cycle.
- R3: The window closes on the P-th edge_i strobe after the opening strobe. count_o then holds the number of clock cycles from the opening strobe's cycle to the closing strobe's cycle.
- R4: A psc_ratio_i of 0 is applied as 1. psc_o reports the ratio applied to the measurement it accompanies.
- R5: done_o is high for exactly one cycle, the cycle after the closing strobe or the abort. count_o, psc_o, ovf_o and tmo_o change only together with done_o and otherwise hold their values.
- R6: A start_i during a measurement is ignored. It changes neither the latched ratio nor the timing of the result.
- R7: count_o is the span modulo 2^CNT_W. ovf_o is 1 exactly when the span is 2^CNT_W or more.
- R8: The limit T is timeout_i latched at start, with 0 applied as 1. The measurement aborts when T cycles pass without a prescaled edge. Before the window opens, the cycles are counted from the start cycle. While it is open, they are counted from the opening strobe. On abort, done_o pulses with tmo_o=1, ovf_o=0, count_o=0 and psc_o=P. A closing strobe that lands in the T-th cycle wins over the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; every register counts or steps on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a measurement; honoured only when idle |
| edge_i | input | 1 | Synchronised one-cycle strobe per rising edge of the unknown signal |
| psc_ratio_i | input | PSC_W | Number of input periods per window (0 acts as 1) |
| timeout_i | input | TMO_W | Cycles allowed without a prescaled edge (0 acts as 1) |
| count_o | output | CNT_W | Measured span N in reference cycles |
| psc_o | output | PSC_W | Ratio P applied to the reported span |
| done_o | output | 1 | One-cycle strobe marking a new result |
| ovf_o | output | 1 | Span did not fit in CNT_W bits |
| tmo_o | output | 1 | Measurement aborted by the timeout |

## Verification
The bench builds the block with CNT_W=12, PSC_W=8 and TMO_W=16. The narrow count lets spans of 4095, 4096 and 5000 cycles reach the wrap boundary and the overflow flag within a few thousand cycles. The 16-bit timeout is wide enough to sit above those long windows. The same timeout can also be set small enough to abort before the first strobe, abort inside the window, or tie with the closing strobe. Random prescale ratios, input periods and first-edge offsets test the window arithmetic. Stray start commands and a strobe in the start cycle test the rules for ignored inputs.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } rpc_state_e;

  // A zero ratio or limit is applied as one.
  function automatic logic [63:0] floor_one(input logic [63:0] v);
    return (v == 64'd0) ? 64'd1 : v;
  endfunction

endpackage

// File: rtl/rpc_edge_div.sv
module rpc_edge_div #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic [PSC_W-1:0] ratio_i,
  output logic             hit_o
);

  logic [PSC_W-1:0] seen_q;

  assign hit_o = en_i & edge_i & (seen_q == ratio_i - PSC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
    end else if (clr_i) begin
      seen_q <= '0;
    end else if (en_i && edge_i) begin
      seen_q <= hit_o ? '0 : seen_q + PSC_W'(1);
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (seen_q < ratio_i)); // R3

endmodule

// File: rtl/rpc_span_cnt.sv
module rpc_span_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] next_o,
  output logic             next_wrap_o
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic             carry;

  assign {carry, next_o} = {1'b0, cnt_q} + EXT_W'(1);
  assign next_wrap_o     = wrap_q | carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (en_i) begin
      cnt_q  <= next_o;
      wrap_q <= next_wrap_o;
    end
  end

  AST_SPAN_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (cnt_q != $past(cnt_q))); // R3

endmodule

// File: rtl/rpc_watchdog.sv
module rpc_watchdog #(
  parameter int TMO_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             pedge_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);

  logic [TMO_W-1:0] wait_q;

  assign expire_o = en_i & ~pedge_i & ((wait_q + TMO_W'(1)) == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
    end else if (clr_i) begin
      wait_q <= '0;
    end else if (en_i) begin
      wait_q <= wait_q + TMO_W'(1);
    end
  end

  AST_WD_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (wait_q < limit_i)); // R8

endmodule

// File: rtl/recip_period_counter.sv
module recip_period_counter #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16,
  parameter int TMO_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             edge_i,
  input  logic [PSC_W-1:0] psc_ratio_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic [CNT_W-1:0] count_o,
  output logic [PSC_W-1:0] psc_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             tmo_o
);
  import rpc_pkg::*;

  rpc_state_e       st_q;
  logic [PSC_W-1:0] p_lat_q;
  logic [TMO_W-1:0] t_lat_q;

  // Named internal events
  logic             start_ev;
  logic             open_ev;
  logic             close_ev;
  logic             tmo_ev;
  logic             pedge_ev;
  logic             fin_ev;
  logic             div_hit;
  logic             in_run;
  logic             waiting;
  logic [CNT_W-1:0] span_next;
  logic             span_wrap;

  assign in_run   = (st_q == ST_RUN);
  assign waiting  = (st_q == ST_ARM) | in_run;
  assign start_ev = (st_q == ST_IDLE) & start_i;
  assign open_ev  = (st_q == ST_ARM) & edge_i;
  assign close_ev = in_run & div_hit;
  assign pedge_ev = open_ev | close_ev;
  assign fin_ev   = close_ev | tmo_ev;

  rpc_edge_div #(.PSC_W(PSC_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (open_ev),
    .en_i    (in_run),
    .edge_i  (edge_i),
    .ratio_i (p_lat_q),
    .hit_o   (div_hit)
  );

  rpc_span_cnt #(.CNT_W(CNT_W)) u_span (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (open_ev),
    .en_i        (in_run),
    .next_o      (span_next),
    .next_wrap_o (span_wrap)
  );

  rpc_watchdog #(.TMO_W(TMO_W)) u_wd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ev | open_ev),
    .en_i     (waiting),
    .pedge_i  (pedge_ev),
    .limit_i  (t_lat_q),
    .expire_o (tmo_ev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      p_lat_q <= '0;
      t_lat_q <= '0;
      count_o <= '0;
      psc_o   <= '0;
      done_o  <= 1'b0;
      ovf_o   <= 1'b0;
      tmo_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_ev) begin
        p_lat_q <= PSC_W'(floor_one(64'(psc_ratio_i)));
        t_lat_q <= TMO_W'(floor_one(64'(timeout_i)));
        st_q    <= ST_ARM;
      end else if (open_ev) begin
        st_q <= ST_RUN;
      end else if (fin_ev) begin
        count_o <= close_ev ? span_next : '0;
        ovf_o   <= close_ev & span_wrap;
        tmo_o   <= ~close_ev;
        psc_o   <= p_lat_q;
        done_o  <= 1'b1;
        st_q    <= ST_IDLE;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_ev |=> ($stable(count_o) && $stable(psc_o) && $stable(ovf_o) && $stable(tmo_o))); // R5
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting && start_i) |=> ($stable(p_lat_q) && $stable(t_lat_q))); // R6
  AST_TMO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && tmo_o) |-> (count_o == '0 && !ovf_o)); // R8
  AST_RATIO_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (psc_o != '0)); // R4

endmodule

// File: tb/recip_period_counter_tb_top.sv
module recip_period_counter_tb_top;

  localparam int CNT_W = 12;
  localparam int PSC_W = 8;
  localparam int TMO_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             edge_i = 1'b0;
  logic [PSC_W-1:0] psc_ratio_i = '0;
  logic [TMO_W-1:0] timeout_i = '0;
  logic [CNT_W-1:0] count_o;
  logic [PSC_W-1:0] psc_o;
  logic             done_o;
  logic             ovf_o;
  logic             tmo_o;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  recip_period_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W), .TMO_W(TMO_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start_i),
    .edge_i      (edge_i),
    .psc_ratio_i (psc_ratio_i),
    .timeout_i   (timeout_i),
    .count_o     (count_o),
    .psc_o       (psc_o),
    .done_o      (done_o),
    .ovf_o       (ovf_o),
    .tmo_o       (tmo_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Expected done cycle (counted from the start cycle) and result fields
  function automatic void predict(input int psc, input int tmo, input int per, input int first,
                                  output int k, output int cnt, output int ovf, output int to);
    int p, t, span;
    p = eff(psc);
    t = eff(tmo);
    span = p * per;
    if (first > t) begin
      k = t; cnt = 0; ovf = 0; to = 1;
    end else if (span > t) begin
      k = first + t; cnt = 0; ovf = 0; to = 1;
    end else begin
      k = first + span; cnt = span % (1 << CNT_W); ovf = (span >= (1 << CNT_W)) ? 1 : 0; to = 0;
    end
  endfunction

  task automatic measure(input int psc, input int tmo, input int per, input int first,
                         input bit edge_at_start, input bit poke);
    int ek, ecnt, eovf, eto;
    int got_k, pulses, cap_cnt, cap_psc, cap_ovf, cap_to;
    predict(psc, tmo, per, first, ek, ecnt, eovf, eto);
    got_k = -1; pulses = 0; cap_cnt = -1; cap_psc = -1; cap_ovf = -1; cap_to = -1;
    @(negedge clk);
    start_i = 1'b1;
    psc_ratio_i = PSC_W'(psc);
    timeout_i = TMO_W'(tmo);
    edge_i = edge_at_start;
    @(posedge clk); #1;
    for (int k = 1; k <= ek + 3; k++) begin
      @(negedge clk);
      start_i = (poke && ek > 4 && k == 2) ? 1'b1 : 1'b0;
      if (start_i) psc_ratio_i = PSC_W'(psc + 1);
      edge_i = (k >= first && ((k - first) % per) == 0 && k <= ek) ? 1'b1 : 1'b0;
      @(posedge clk); #1;
      if (done_o) begin
        pulses++;
        if (got_k < 0) begin
          got_k = k; cap_cnt = int'(count_o); cap_psc = int'(psc_o);
          cap_ovf = int'(ovf_o); cap_to = int'(tmo_o);
        end
      end
    end
    edge_i = 1'b0;
    chk(eto ? "R8 done cycle" : "R3 done cycle", got_k, ek);
    chk("R3 R7 count", cap_cnt, ecnt);
    chk("R4 R6 ratio", cap_psc, eff(psc));
    chk("R7 overflow flag", cap_ovf, eovf);
    chk("R8 timeout flag", cap_to, eto);
    chk("R5 single pulse", pulses, 1);
    chk("R5 hold count", int'(count_o), cap_cnt);
    chk("R5 hold flags", int'({ovf_o, tmo_o}), cap_ovf * 2 + cap_to);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0101));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 count after reset", int'(count_o), 0);
    chk("R1 ratio after reset", int'(psc_o), 0);
    chk("R1 flags after reset", int'({ovf_o, tmo_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    measure(1, 1000, 7, 1, 1'b0, 1'b0);     // R3 basic
    measure(0, 1000, 9, 3, 1'b0, 1'b0);     // R4 zero ratio
    measure(4, 1000, 3, 2, 1'b1, 1'b1);     // R2 start-cycle edge, R6 stray start
    measure(2, 10, 5, 20, 1'b0, 1'b0);      // R8 abort before opening
    measure(3, 25, 10, 2, 1'b0, 1'b1);      // R8 abort inside window
    measure(3, 30, 10, 2, 1'b0, 1'b0);      // R8 tie: close wins
    measure(1, 0, 3, 2, 1'b0, 1'b0);        // R8 zero limit acts as one
    measure(1, 6000, 4095, 1, 1'b0, 1'b0);  // R7 just below wrap
    measure(2, 6000, 2048, 1, 1'b0, 1'b0);  // R7 exactly 2^CNT_W
    measure(1, 6000, 5000, 1, 1'b0, 1'b0);  // R7 beyond wrap

    for (int i = 0; i < 30; i++) begin
      int p, per, first;
      p = int'($urandom_range(1, 6));
      per = int'($urandom_range(1, 20));
      first = int'($urandom_range(1, 10));
      measure(p, 1000, per, first, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule